// File: doc/BRIEF.md
# USB Host Transmit Prefill Scheduler

This block decides when a host-mode USB transmit packet may go onto the bus. The latency FIFO ahead of the serializer is filled from system memory in bursts. An external counter reports how many bursts are already posted, and the block holds the packet back until that count reaches a programmed burst threshold. This protects the serializer from an underrun that would occur if it drained the FIFO faster than memory could refill it. A stream-disable input bypasses the wait.

The block also checks the time left before the next Start-Of-Frame. A packet time estimate in clock cycles is added to a programmable overhead, which is counted in units converted to cycles by a parameter. When that sum exceeds the cycles left before the frame boundary, the packet is deferred until the next SOF pulse. If the FIFO had also not reached its threshold, the event is counted in a 5-bit health counter that saturates. Software tunes the overhead until this counter stays low.

A 32-bit tuning register holds the threshold, the overhead and the health counter. It is reached through a synchronous write-enable and registered read-data port. The FIFO, DMA, serializer and frame timer sit outside the block and are seen only as counts and strobes.

Top module: `tx_prefill_sched`

## Requirements
- R1: After a synchronous reset, every register field reads zero, and tx_go, backoff and deferred are low.
- R2: Register layout: threshold in bits 21:16, health counter in bits 12:8, overhead in bits 6:0. All other bits read zero and writes to them have no effect. reg_rdata shows the register one cycle after it changes.
- R3: When ctrl_mode changes to host (2'b11) from any other code, the threshold field is reloaded with 2.
- R4: A threshold field of 0 or 1 gates exactly like a threshold of 2.
- R5: In host mode with a pending packet, tx_go is high in the cycle after burst_cnt is at or above the effective threshold and the deadline is met. It is low in the cycle after burst_cnt is below the threshold.
- R6: While stream_dis is high, the threshold is ignored and a pending packet that meets the deadline gets tx_go even with burst_cnt at zero.
- R7: In host mode, a deadline miss is pkt_est_cyc + overhead*CYC_PER_UNIT strictly greater than sof_remain_cyc; equality is not a miss. A miss on a pending packet pulses backoff, raises deferred and keeps tx_go low.
- R8: The health counter increments on a deadline miss only if the burst threshold was not reached. A miss with the FIFO already prefilled does not count.
- R9: The health counter stops at 31 and does not wrap.
- R10: Any register write clears the health counter, whatever the data in bits 12:8. A write wins over an increment in the same cycle.
- R11: Once deferred, no tx_go or further back-off occurs until an sof_pulse clears deferred. The packet is then evaluated again in the following cycle.
- R12: Outside host mode, tx_go follows pkt_pending with no threshold or deadline gate, and backoff and deferred stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_mode | input | 2 | Controller mode code, 2'b11 is host |
| stream_dis | input | 1 | Bypass the prefill threshold |
| reg_we | input | 1 | Tuning register write strobe |
| reg_wdata | input | 32 | Tuning register write data |
| reg_rdata | output | 32 | Tuning register read data (registered) |
| burst_cnt | input | CNT_W | Bursts currently posted to the latency FIFO |
| pkt_pending | input | 1 | A transmit packet is waiting to start |
| pkt_est_cyc | input | TIME_W | Estimated packet duration in cycles |
| sof_remain_cyc | input | TIME_W | Cycles left before the next SOF |
| sof_pulse | input | 1 | One-cycle Start-Of-Frame strobe |
| tx_go | output | 1 | Permission for the pending packet to start |
| backoff | output | 1 | One-cycle pulse on a deadline miss |
| deferred | output | 1 | Packet held until the next SOF |

## Verification
The assertions assume that burst_cnt, pkt_est_cyc and sof_remain_cyc are steady, valid levels sampled each clock. They also assume that sof_pulse lasts one cycle and that ctrl_mode does not change in the same cycle as a register write. The stimulus changes every input only at the falling edge. It raises sof_pulse for single cycles and drops pkt_pending around each SOF pulse, so that every deadline miss is counted exactly once. It never writes the register in the cycle that host mode is entered.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam logic [1:0] MODE_HOST = 2'b11;
  localparam int THR_MIN    = 2;
  localparam int THR_RELOAD = 2;
  localparam int THR_LSB    = 16;
  localparam int HC_LSB     = 8;
  localparam int OH_LSB     = 0;
  localparam int REG_W      = 32;
endpackage

// File: rtl/tps_tune_reg.sv
module tps_tune_reg
  import tps_pkg::*;
#(
  parameter int THR_W = 6,
  parameter int HC_W  = 5,
  parameter int OH_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_mode,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             cnt_evt,
  output logic [THR_W-1:0] thr,
  output logic [OH_W-1:0]  oh,
  output logic [REG_W-1:0] rdata
);
  localparam logic [HC_W-1:0] HC_MAX = {HC_W{1'b1}};

  logic            host_q;
  logic [HC_W-1:0] hc;
  logic            host_entry;
  logic [REG_W-1:0] rd_n;

  assign host_entry = host_mode && !host_q;

  always_comb begin
    rd_n = '0;
    rd_n[THR_LSB +: THR_W] = thr;
    rd_n[HC_LSB  +: HC_W]  = hc;
    rd_n[OH_LSB  +: OH_W]  = oh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_q <= 1'b0;
      thr    <= '0;
      oh     <= '0;
      hc     <= '0;
      rdata  <= '0;
    end else begin
      host_q <= host_mode;
      if (we) begin
        thr <= wdata[THR_LSB +: THR_W];
        oh  <= wdata[OH_LSB  +: OH_W];
      end
      if (host_entry) thr <= THR_W'(THR_RELOAD);
      if (we)                          hc <= '0;
      else if (cnt_evt && hc != HC_MAX) hc <= hc + 1'b1;
      rdata <= rd_n;
    end
  end

  // R9: saturation holds without a write
  a_r9_hc_saturates: assert property (@(posedge clk) disable iff (rst)
    (hc == HC_MAX && !we) |=> hc == HC_MAX);
  // R10: a write always leaves the counter at zero
  a_r10_write_clears: assert property (@(posedge clk) disable iff (rst)
    we |=> hc == '0);
  // R3: entering host mode reloads the threshold
  a_r3_host_reload: assert property (@(posedge clk) disable iff (rst)
    (host_mode && !host_q) |=> thr == THR_W'(THR_RELOAD));
endmodule

// File: rtl/tps_deadline.sv
module tps_deadline #(
  parameter int TIME_W       = 16,
  parameter int OH_W         = 7,
  parameter int CYC_PER_UNIT = 317
) (
  input  logic [TIME_W-1:0] pkt_est_cyc,
  input  logic [TIME_W-1:0] sof_remain_cyc,
  input  logic [OH_W-1:0]   oh,
  output logic              late
);
  localparam int PROD_W = OH_W + $clog2(CYC_PER_UNIT + 1);
  localparam int SUM_W  = ((PROD_W > TIME_W) ? PROD_W : TIME_W) + 1;

  logic [SUM_W-1:0] need;

  assign need = SUM_W'(pkt_est_cyc) + SUM_W'(oh) * SUM_W'(CYC_PER_UNIT);
  assign late = need > SUM_W'(sof_remain_cyc);
endmodule

// File: rtl/tps_gate.sv
module tps_gate
  import tps_pkg::*;
#(
  parameter int THR_W = 6,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_mode,
  input  logic             stream_dis,
  input  logic [THR_W-1:0] thr,
  input  logic [CNT_W-1:0] burst_cnt,
  input  logic             pkt_pending,
  input  logic             late,
  input  logic             sof_pulse,
  output logic             cnt_evt,
  output logic             tx_go,
  output logic             backoff,
  output logic             deferred
);
  localparam int CMP_W = ((THR_W > CNT_W) ? THR_W : CNT_W) + 1;

  logic [CMP_W-1:0] eff_thr;
  logic             ready;
  logic             eval;
  logic             go_n, bo_n, def_n;

  assign eff_thr = (thr < THR_W'(THR_MIN)) ? CMP_W'(THR_MIN) : CMP_W'(thr);
  assign ready   = stream_dis || (CMP_W'(burst_cnt) >= eff_thr);
  assign eval    = host_mode && pkt_pending && !deferred;

  always_comb begin
    go_n    = 1'b0;
    bo_n    = 1'b0;
    cnt_evt = 1'b0;
    def_n   = deferred;
    if (sof_pulse) def_n = 1'b0;
    if (!host_mode) begin
      go_n  = pkt_pending;
      def_n = 1'b0;
    end else if (eval) begin
      if (late) begin
        bo_n    = 1'b1;
        def_n   = 1'b1;
        cnt_evt = !ready;
      end else begin
        go_n = ready;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_go    <= 1'b0;
      backoff  <= 1'b0;
      deferred <= 1'b0;
    end else begin
      tx_go    <= go_n;
      backoff  <= bo_n;
      deferred <= def_n;
    end
  end

  // R4/R5: in host mode with streaming on, no start below two bursts
  a_r4_min_prefill: assert property (@(posedge clk) disable iff (rst)
    (tx_go && $past(host_mode && !stream_dis)) |-> $past(burst_cnt) >= CNT_W'(THR_MIN));
  // R7: a back-off never coincides with a start
  a_r7_no_go_on_backoff: assert property (@(posedge clk) disable iff (rst)
    !(tx_go && backoff));
  // R11: a deferred packet cannot start in the next cycle
  a_r11_defer_blocks: assert property (@(posedge clk) disable iff (rst)
    (deferred && host_mode) |=> !tx_go);
  // R12: outside host mode nothing is deferred
  a_r12_nonhost_clear: assert property (@(posedge clk) disable iff (rst)
    !host_mode |=> !deferred && !backoff);
endmodule

// File: rtl/tx_prefill_sched.sv
module tx_prefill_sched
  import tps_pkg::*;
#(
  parameter int THR_W        = 6,
  parameter int HC_W         = 5,
  parameter int OH_W         = 7,
  parameter int CNT_W        = 6,
  parameter int TIME_W       = 16,
  parameter int CYC_PER_UNIT = 317
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ctrl_mode,
  input  logic              stream_dis,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [CNT_W-1:0]  burst_cnt,
  input  logic              pkt_pending,
  input  logic [TIME_W-1:0] pkt_est_cyc,
  input  logic [TIME_W-1:0] sof_remain_cyc,
  input  logic              sof_pulse,
  output logic              tx_go,
  output logic              backoff,
  output logic              deferred
);
  logic             host_mode;
  logic [THR_W-1:0] thr;
  logic [OH_W-1:0]  oh;
  logic             late;
  logic             cnt_evt;

  assign host_mode = (ctrl_mode == MODE_HOST);

  tps_tune_reg #(.THR_W(THR_W), .HC_W(HC_W), .OH_W(OH_W)) u_reg (
    .clk(clk), .rst(rst), .host_mode(host_mode), .we(reg_we),
    .wdata(reg_wdata), .cnt_evt(cnt_evt), .thr(thr), .oh(oh), .rdata(reg_rdata)
  );

  tps_deadline #(.TIME_W(TIME_W), .OH_W(OH_W), .CYC_PER_UNIT(CYC_PER_UNIT)) u_dl (
    .pkt_est_cyc(pkt_est_cyc), .sof_remain_cyc(sof_remain_cyc), .oh(oh), .late(late)
  );

  tps_gate #(.THR_W(THR_W), .CNT_W(CNT_W)) u_gate (
    .clk(clk), .rst(rst), .host_mode(host_mode), .stream_dis(stream_dis),
    .thr(thr), .burst_cnt(burst_cnt), .pkt_pending(pkt_pending), .late(late),
    .sof_pulse(sof_pulse), .cnt_evt(cnt_evt), .tx_go(tx_go),
    .backoff(backoff), .deferred(deferred)
  );
endmodule

// File: tb/tx_prefill_sched_tb_top.sv
`timescale 1ns/1ps
module tx_prefill_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  ctrl_mode;
  logic        stream_dis, reg_we, pkt_pending, sof_pulse;
  logic [31:0] reg_wdata, reg_rdata;
  logic [5:0]  burst_cnt;
  logic [15:0] pkt_est_cyc, sof_remain_cyc;
  logic        tx_go, backoff, deferred;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tx_prefill_sched dut_i (
    .clk(clk), .rst(rst), .ctrl_mode(ctrl_mode), .stream_dis(stream_dis),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .burst_cnt(burst_cnt), .pkt_pending(pkt_pending), .pkt_est_cyc(pkt_est_cyc),
    .sof_remain_cyc(sof_remain_cyc), .sof_pulse(sof_pulse), .tx_go(tx_go),
    .backoff(backoff), .deferred(deferred)
  );

  function automatic logic [31:0] fld(int t, int h, int o);
    logic [31:0] v = '0;
    v[21:16] = t[5:0];
    v[12:8]  = h[4:0];
    v[6:0]   = o[6:0];
    return v;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    reg_we = 1'b1; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [31:0] exp);
    step();
    chk(req, reg_rdata, exp);
  endtask

  task automatic t_reset();
    chk("R1 tx_go", {31'b0, tx_go}, 0);
    chk("R1 backoff", {31'b0, backoff}, 0);
    chk("R1 deferred", {31'b0, deferred}, 0);
    chk("R1 rdata", reg_rdata, 0);
  endtask

  task automatic t_layout();
    wr(32'hFFFF_FFFF);
    rd_chk("R2 all ones", 32'h003F_007F);
    wr(32'hFFC0_FF80);
    rd_chk("R2 reserved only", 32'h0);
  endtask

  task automatic t_host_entry();
    wr(fld(10, 0, 0));
    ctrl_mode = 2'b11;
    step();
    rd_chk("R3 reload", fld(2, 0, 0));
  endtask

  task automatic t_min_thr();
    wr(fld(0, 0, 0));
    pkt_est_cyc = 10; sof_remain_cyc = 1000; pkt_pending = 1; burst_cnt = 1;
    step(); chk("R4 thr0 one burst", {31'b0, tx_go}, 0);
    burst_cnt = 2;
    step(); chk("R4 thr0 two bursts", {31'b0, tx_go}, 1);
    pkt_pending = 0;
    wr(fld(1, 0, 0));
    pkt_pending = 1; burst_cnt = 1;
    step(); chk("R4 thr1 one burst", {31'b0, tx_go}, 0);
    pkt_pending = 0; step();
  endtask

  task automatic t_thresh();
    wr(fld(5, 0, 0));
    pkt_pending = 1; burst_cnt = 4;
    step(); chk("R5 below", {31'b0, tx_go}, 0);
    burst_cnt = 5;
    step(); chk("R5 at threshold", {31'b0, tx_go}, 1);
    pkt_pending = 0; step();
  endtask

  task automatic t_stream();
    burst_cnt = 0; stream_dis = 1; pkt_pending = 1;
    step(); chk("R6 stream bypass", {31'b0, tx_go}, 1);
    stream_dis = 0;
    step(); chk("R5 empty fifo", {31'b0, tx_go}, 0);
    pkt_pending = 0; step();
  endtask

  task automatic t_late();
    wr(fld(5, 0, 1));
    burst_cnt = 5; pkt_est_cyc = 100; sof_remain_cyc = 417; pkt_pending = 1;
    step();
    chk("R7 equal fits go", {31'b0, tx_go}, 1);
    chk("R7 equal no backoff", {31'b0, backoff}, 0);
    sof_remain_cyc = 416;
    step();
    chk("R7 miss go", {31'b0, tx_go}, 0);
    chk("R7 miss backoff", {31'b0, backoff}, 1);
    chk("R7 miss deferred", {31'b0, deferred}, 1);
    rd_chk("R8 prefilled miss uncounted", fld(5, 0, 1));
    sof_remain_cyc = 1000;
    step();
    chk("R11 held go", {31'b0, tx_go}, 0);
    chk("R11 no repeat backoff", {31'b0, backoff}, 0);
    sof_pulse = 1;
    step();
    chk("R11 sof cycle go", {31'b0, tx_go}, 0);
    chk("R11 sof clears", {31'b0, deferred}, 0);
    sof_pulse = 0;
    step();
    chk("R11 rearmed go", {31'b0, tx_go}, 1);
    pkt_pending = 0; step();
  endtask

  task automatic miss_once();
    pkt_pending = 0; sof_pulse = 1; step();
    sof_pulse = 0; pkt_pending = 1; step();
  endtask

  task automatic t_health();
    burst_cnt = 0; sof_remain_cyc = 0; pkt_est_cyc = 100;
    for (int i = 0; i < 5; i++) miss_once();
    chk("R8 unfilled backoff", {31'b0, backoff}, 1);
    pkt_pending = 0;
    rd_chk("R8 count five", fld(5, 5, 1));
    for (int i = 0; i < 30; i++) miss_once();
    pkt_pending = 0;
    rd_chk("R9 saturate", fld(5, 31, 1));
  endtask

  task automatic t_clear();
    pkt_pending = 0; sof_pulse = 1; step(); sof_pulse = 0;
    pkt_pending = 1; reg_we = 1; reg_wdata = fld(5, 0, 1);
    step();
    reg_we = 0; reg_wdata = '0; pkt_pending = 0;
    rd_chk("R10 write beats increment", fld(5, 0, 1));
    miss_once();
    pkt_pending = 0;
    rd_chk("R10 count one", fld(5, 1, 1));
    wr(fld(5, 31, 1));
    rd_chk("R10 data ignored clear", fld(5, 0, 1));
  endtask

  task automatic t_nonhost();
    ctrl_mode = 2'b01; pkt_pending = 1; burst_cnt = 0; sof_remain_cyc = 0;
    step();
    chk("R12 go follows pending", {31'b0, tx_go}, 1);
    chk("R12 no backoff", {31'b0, backoff}, 0);
    chk("R12 no deferred", {31'b0, deferred}, 0);
    pkt_pending = 0;
    step();
    chk("R12 go drops", {31'b0, tx_go}, 0);
    rd_chk("R12 health untouched", fld(5, 0, 1));
  endtask

  initial begin
    rst = 1; ctrl_mode = 2'b00; stream_dis = 0; reg_we = 0; reg_wdata = '0;
    burst_cnt = 0; pkt_pending = 0; pkt_est_cyc = 0; sof_remain_cyc = 0; sof_pulse = 0;
    @(negedge clk);
    step(); step(); step();
    rst = 0;
    step();
    t_reset();
    t_layout();
    t_host_entry();
    t_min_thr();
    t_thresh();
    t_stream();
    t_late();
    t_health();
    t_clear();
    t_nonhost();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule